// File: doc/BRIEF.md
# Region Access Checker

This block decides whether one memory access may proceed under a table of eight
protection regions. Each request carries an address, a privilege flag, an access
kind (read, write or instruction fetch) and a flag saying the processor runs in an
elevated fault handler. The block returns whether the access faults, whether a
region matched, and which region matched. Each region is a power-of-two window
aligned to its own size. It is split into eight equal sub-regions, and each
sub-region can be removed from the window on its own. A region also holds a 3-bit
permission code and an execute-never bit.

Global control bits switch the unit on, enable a background map for privileged
code when no region matches, and keep the unit active inside elevated handlers.
The region table and control bits are plain inputs. They are sampled together
with the request.

Requests enter on a valid/ready port. `req_ready` equals `!rsp_valid || rsp_ready`,
so a new request is taken in the same cycle a waiting result is consumed. A result
appears on `rsp_*` in the cycle after its request is accepted. It stays unchanged
while `rsp_ready` is low.

Top module: `mem_region_guard`

## Requirements
- R1: Region size code s (0..31) spans 2^(s+1) bytes. A region matches only when it is enabled, s is at least 4, and address bits above bit s equal the same bits of its base. Codes 0 to 3 never match, and s=31 matches every address.
- R2: For s of 7 or more, the sub-region index is address bits [s:s-2]. When bit k of the region's disable mask is set, an address in sub-region k does not match that region.
- R3: For s of 6 or less, the disable mask has no effect on matching.
- R4: When several regions match, the highest-numbered one decides the permission and is reported on `rsp_idx`, with `rsp_hit`=1.
- R5: Permission codes give (privileged, user) rights: 000 none/none, 001 rw/none, 010 rw/ro, 011 rw/rw, 100 none/none, 101 ro/none, 110 and 111 ro/ro. Access kind 0 is read, 1 is write, and 2 and 3 are fetch. A fetch needs read rights.
- R6: A fetch that hits a region with execute-never set faults, whatever its permission code allows.
- R7: With `ctl_enable`=0, every access is allowed, and it reports `rsp_hit`=0 and `rsp_idx`=0.
- R8: When active and no region matches, the result reports `rsp_hit`=0 and `rsp_idx`=0. A privileged access is allowed only when `ctl_bg_priv`=1, and a user access always faults.
- R9: With `req_elevated`=1, the unit is active only when both `ctl_elev_enable` and `ctl_enable` are 1. Otherwise it behaves as in R7.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is `!rsp_valid || rsp_ready`. The result is valid in the next cycle and holds stable while `rsp_ready`=0.
- R11: After reset, `rsp_valid`, `rsp_fault`, `rsp_hit` and `rsp_idx` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Access address |
| req_priv | input | 1 | 1 = privileged access |
| req_kind | input | 2 | 0 read, 1 write, 2/3 fetch |
| req_elevated | input | 1 | Access from an elevated fault handler |
| ctl_enable | input | 1 | Unit enable |
| ctl_bg_priv | input | 1 | Background map for privileged accesses |
| ctl_elev_enable | input | 1 | Keep unit active in elevated handlers |
| rgn_enable | input | NREG | Per-region enable |
| rgn_base | input | NREG x AW | Per-region base address |
| rgn_size | input | NREG x 5 | Per-region size code |
| rgn_srd | input | NREG x 8 | Per-region sub-region disable mask |
| rgn_ap | input | NREG x 3 | Per-region permission code |
| rgn_xn | input | NREG | Per-region execute-never |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Access is refused |
| rsp_hit | output | 1 | A region decided the result |
| rsp_idx | output | IDXW | Deciding region number |

## Verification
The properties assume that the consumer only lowers `rsp_ready` while a result is
pending. They also assume that the region table and control bits are meaningful
in the cycle a request is accepted, because the result is computed from those
values alone. The stimulus changes the region table only while no request is
outstanding. It applies every input change half a cycle away from the sampling
edge. Back-pressure is exercised by holding `rsp_ready` low while a different
request waits at the input, then releasing it so that one edge both drains the
old result and accepts the new request.

// File: rtl/mem_region_guard_pkg.sv
package mem_region_guard_pkg;

  localparam int SIZE_W      = 5;
  localparam int SUB_W       = 8;
  localparam int AP_W        = 3;
  localparam int MIN_SIZE    = 4;
  localparam int SUB_MIN_SIZE = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_FETCH2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic p_rd;
    logic p_wr;
    logic u_rd;
    logic u_wr;
  } rights_t;

  function automatic rights_t ap_rights(input logic [AP_W-1:0] code);
    rights_t r;
    case (code)
      3'b001:  r = '{p_rd: 1'b1, p_wr: 1'b1, u_rd: 1'b0, u_wr: 1'b0};
      3'b010:  r = '{p_rd: 1'b1, p_wr: 1'b1, u_rd: 1'b1, u_wr: 1'b0};
      3'b011:  r = '{p_rd: 1'b1, p_wr: 1'b1, u_rd: 1'b1, u_wr: 1'b1};
      3'b101:  r = '{p_rd: 1'b1, p_wr: 1'b0, u_rd: 1'b0, u_wr: 1'b0};
      3'b110,
      3'b111:  r = '{p_rd: 1'b1, p_wr: 1'b0, u_rd: 1'b1, u_wr: 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mrg_region_match.sv
module mrg_region_match
  import mem_region_guard_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              en_i,
  input  logic [AW-1:0]     base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SUB_W-1:0]  srd_i,
  output logic              match_o
);

  logic          legal;
  logic          upper_diff;
  logic [AW-1:0] shifted;
  logic [2:0]    sub_idx;
  logic          sub_off;

  assign legal = (size_i >= SIZE_W'(MIN_SIZE));

  always_comb begin
    upper_diff = 1'b0;
    for (int i = 0; i < AW; i++) begin
      if ((7'(i) > {2'b00, size_i}) && (addr_i[i] != base_i[i])) upper_diff = 1'b1;
    end
  end

  // Sub-region index sits just below the top bit of the window.
  assign shifted = addr_i >> (size_i - SIZE_W'(2));
  assign sub_idx = shifted[2:0];
  assign sub_off = (size_i >= SIZE_W'(SUB_MIN_SIZE)) && srd_i[sub_idx];

  assign match_o = en_i && legal && !upper_diff && !sub_off;

endmodule

// File: rtl/mrg_region_pick.sv
module mrg_region_pick
  import mem_region_guard_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]           match_i,
  input  logic [NREG-1:0][AP_W-1:0] ap_i,
  input  logic [NREG-1:0]           xn_i,
  output logic                      hit_o,
  output logic [IDXW-1:0]           idx_o,
  output logic [AP_W-1:0]           ap_o,
  output logic                      xn_o
);

  // Ascending scan: a later (higher-numbered) match overrides earlier ones.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    ap_o  = '0;
    xn_o  = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (match_i[r]) begin
        hit_o = 1'b1;
        idx_o = IDXW'(r);
        ap_o  = ap_i[r];
        xn_o  = xn_i[r];
      end
    end
  end

  // R4: no matching region numbered above the chosen one
  always_comb begin
    if (hit_o) begin
      a_r4_highest: assert ((match_i >> idx_o) == NREG'(1));
    end
  end

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mem_region_guard_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [AW-1:0]               req_addr,
  input  logic                        req_priv,
  input  logic [1:0]                  req_kind,
  input  logic                        req_elevated,
  input  logic                        ctl_enable,
  input  logic                        ctl_bg_priv,
  input  logic                        ctl_elev_enable,
  input  logic [NREG-1:0]             rgn_enable,
  input  logic [NREG-1:0][AW-1:0]     rgn_base,
  input  logic [NREG-1:0][SIZE_W-1:0] rgn_size,
  input  logic [NREG-1:0][SUB_W-1:0]  rgn_srd,
  input  logic [NREG-1:0][AP_W-1:0]   rgn_ap,
  input  logic [NREG-1:0]             rgn_xn,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_fault,
  output logic                        rsp_hit,
  output logic [IDXW-1:0]             rsp_idx
);

  logic [NREG-1:0] match_vec;
  logic            sel_hit;
  logic [IDXW-1:0] sel_idx;
  logic [AP_W-1:0] sel_ap;
  logic            sel_xn;
  logic            active;
  logic            allow;
  logic            take;
  rights_t         rights;
  acc_kind_e       kind;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    mrg_region_match #(.AW(AW)) match_i (
      .addr_i  (req_addr),
      .en_i    (rgn_enable[g]),
      .base_i  (rgn_base[g]),
      .size_i  (rgn_size[g]),
      .srd_i   (rgn_srd[g]),
      .match_o (match_vec[g])
    );
  end

  mrg_region_pick #(.NREG(NREG)) pick_i (
    .match_i (match_vec),
    .ap_i    (rgn_ap),
    .xn_i    (rgn_xn),
    .hit_o   (sel_hit),
    .idx_o   (sel_idx),
    .ap_o    (sel_ap),
    .xn_o    (sel_xn)
  );

  assign kind   = acc_kind_e'(req_kind);
  assign rights = ap_rights(sel_ap);
  assign active = ctl_enable && (!req_elevated || ctl_elev_enable);

  always_comb begin
    if (!active) begin
      allow = 1'b1;
    end else if (!sel_hit) begin
      allow = req_priv && ctl_bg_priv;
    end else begin
      unique case (kind)
        ACC_READ:  allow = req_priv ? rights.p_rd : rights.u_rd;
        ACC_WRITE: allow = req_priv ? rights.p_wr : rights.u_wr;
        default:   allow = !sel_xn && (req_priv ? rights.p_rd : rights.u_rd);
      endcase
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fault <= !allow;
      rsp_hit   <= active && sel_hit;
      rsp_idx   <= (active && sel_hit) ? sel_idx : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: an accepted request yields a result next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R10: a stalled result is held unchanged
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_fault, rsp_hit, rsp_idx})));

  // R7: a disabled unit allows everything and reports no hit
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ctl_enable) |=> (!rsp_fault && !rsp_hit && rsp_idx == '0));

  // R9: elevated handlers bypass unless kept active
  a_r9_elev_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_elevated && !ctl_elev_enable) |=> (!rsp_fault && !rsp_hit));

  // R8: a result without a hit names region zero
  a_r8_miss_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0));

endmodule

// File: tb/mem_region_guard_tb_top.sv
`timescale 1ns/1ps
module mem_region_guard_tb_top;

  localparam int AW   = 32;
  localparam int NREG = 8;
  localparam int NV   = 30;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic [AW-1:0]          req_addr = '0;
  logic                   req_priv = 1'b0;
  logic [1:0]             req_kind = 2'd0;
  logic                   req_elevated = 1'b0;
  logic                   ctl_enable = 1'b0;
  logic                   ctl_bg_priv = 1'b0;
  logic                   ctl_elev_enable = 1'b0;
  logic [NREG-1:0]        rgn_enable;
  logic [NREG-1:0][AW-1:0] rgn_base;
  logic [NREG-1:0][4:0]   rgn_size;
  logic [NREG-1:0][7:0]   rgn_srd;
  logic [NREG-1:0][2:0]   rgn_ap;
  logic [NREG-1:0]        rgn_xn;
  logic                   rsp_valid;
  logic                   rsp_ready = 1'b1;
  logic                   rsp_fault;
  logic                   rsp_hit;
  logic [2:0]             rsp_idx;

  int checks = 0;
  int errors = 0;

  mem_region_guard #(.AW(AW), .NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_priv(req_priv), .req_kind(req_kind),
    .req_elevated(req_elevated),
    .ctl_enable(ctl_enable), .ctl_bg_priv(ctl_bg_priv),
    .ctl_elev_enable(ctl_elev_enable),
    .rgn_enable(rgn_enable), .rgn_base(rgn_base), .rgn_size(rgn_size),
    .rgn_srd(rgn_srd), .rgn_ap(rgn_ap), .rgn_xn(rgn_xn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
  );

  // Vector: {req#(4), addr(32), priv, kind(2), en, bg, elev_en, elev, exp_fault, exp_hit, exp_idx(3)}
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 32'h2000_0010, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R1 r0 user read
    {4'd6, 32'h2000_0010, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R6 xn fetch
    {4'd4, 32'h2000_4100, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R4 r1 over r0, ro
    {4'd4, 32'h2000_4100, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R4
    {4'd1, 32'h2000_5000, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R1 outside r1
    {4'd5, 32'h0800_0800, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R5 010 user ro
    {4'd5, 32'h0800_0800, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2}, // R5
    {4'd2, 32'h0800_1200, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R2 sub 2 off
    {4'd8, 32'h0800_1200, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R8 bg priv
    {4'd2, 32'h0800_1800, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R2 sub 3 on
    {4'd3, 32'h4000_0050, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R3 mask ignored
    {4'd5, 32'h4000_0050, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3}, // R5 101 priv ro
    {4'd5, 32'h4000_0050, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3}, // R5 101 user none
    {4'd1, 32'h4000_0080, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R1 past 128B
    {4'd1, 32'h5000_0000, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R1 disabled rgn
    {4'd8, 32'h5000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R8 user miss
    {4'd1, 32'h6000_0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R1 size code 3
    {4'd5, 32'h7000_0100, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6}, // R5 001 priv rw
    {4'd5, 32'h7000_0100, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6}, // R5 001 user
    {4'd5, 32'h7000_1010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7}, // R5 000
    {4'd1, 32'h7000_1020, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R1 32B edge
    {4'd7, 32'h7000_1010, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R7 disabled unit
    {4'd9, 32'h7000_1010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R9 elev bypass
    {4'd9, 32'h7000_1010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd7}, // R9 elev active
    {4'd9, 32'h7000_1010, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0}, // R9 needs enable
    {4'd5, 32'h2000_4100, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R5 fetch ro ok
    {4'd5, 32'h0800_0800, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R5 fetch
    {4'd6, 32'h2000_0010, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R6 kind 3 fetch
    {4'd1, 32'h2001_0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R1 past 64KB
    {4'd2, 32'h0800_3FFF, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2}  // R2 sub 7 on
  };

  task automatic check_rsp(input int rq, input logic ef, input logic eh, input logic [2:0] ei);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_hit !== eh || rsp_idx !== ei) begin
      errors++;
      $display("FAIL R%0d addr=%h: got v=%b f=%b h=%b i=%0d, expected v=1 f=%b h=%b i=%0d",
               rq, req_addr, rsp_valid, rsp_fault, rsp_hit, rsp_idx, ef, eh, ei);
    end
  endtask

  // Issue one request at a falling edge, sample the result one cycle later.
  task automatic run_one(input logic [31:0] a, input logic p, input logic [1:0] k,
                         input logic en, input logic bg, input logic ee, input logic el,
                         input int rq, input logic ef, input logic eh, input logic [2:0] ei);
    @(negedge clk);
    req_addr = a; req_priv = p; req_kind = k;
    ctl_enable = en; ctl_bg_priv = bg; ctl_elev_enable = ee; req_elevated = el;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(rq, ef, eh, ei);
  endtask

  initial begin
    rgn_enable = 8'b1110_1111;
    rgn_base[0] = 32'h2000_0000; rgn_size[0] = 5'd15; rgn_srd[0] = 8'h00; rgn_ap[0] = 3'b011; rgn_xn[0] = 1'b1;
    rgn_base[1] = 32'h2000_4000; rgn_size[1] = 5'd11; rgn_srd[1] = 8'h00; rgn_ap[1] = 3'b110; rgn_xn[1] = 1'b0;
    rgn_base[2] = 32'h0800_0000; rgn_size[2] = 5'd13; rgn_srd[2] = 8'h04; rgn_ap[2] = 3'b010; rgn_xn[2] = 1'b0;
    rgn_base[3] = 32'h4000_0000; rgn_size[3] = 5'd6;  rgn_srd[3] = 8'hFF; rgn_ap[3] = 3'b101; rgn_xn[3] = 1'b0;
    rgn_base[4] = 32'h5000_0000; rgn_size[4] = 5'd9;  rgn_srd[4] = 8'h00; rgn_ap[4] = 3'b011; rgn_xn[4] = 1'b0;
    rgn_base[5] = 32'h6000_0000; rgn_size[5] = 5'd3;  rgn_srd[5] = 8'h00; rgn_ap[5] = 3'b011; rgn_xn[5] = 1'b0;
    rgn_base[6] = 32'h7000_0000; rgn_size[6] = 5'd9;  rgn_srd[6] = 8'h00; rgn_ap[6] = 3'b001; rgn_xn[6] = 1'b0;
    rgn_base[7] = 32'h7000_1000; rgn_size[7] = 5'd4;  rgn_srd[7] = 8'h00; rgn_ap[7] = 3'b000; rgn_xn[7] = 1'b0;

    // R11: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_hit !== 1'b0 || rsp_idx !== 3'd0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: got v=%b f=%b h=%b i=%0d rdy=%b, expected 0 0 0 0 1",
               rsp_valid, rsp_fault, rsp_hit, rsp_idx, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      run_one(VEC[n][43:12], VEC[n][11], VEC[n][10:9], VEC[n][8], VEC[n][7], VEC[n][6],
              VEC[n][5], int'(VEC[n][47:44]), VEC[n][4], VEC[n][3], VEC[n][2:0]);
    end

    // R5: reserved code 100 denies privileged read
    @(negedge clk); rgn_ap[6] = 3'b100;
    run_one(32'h7000_0100, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5, 1'b1, 1'b1, 3'd6);
    @(negedge clk); rgn_ap[6] = 3'b001;

    // R1: size code 31 covers every address; R4: it also outranks region 0
    @(negedge clk); rgn_size[7] = 5'd31;
    run_one(32'hDEAD_BEEC, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1, 3'd7);
    run_one(32'h2000_0010, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b1, 1'b1, 3'd7);
    @(negedge clk); rgn_size[7] = 5'd4;

    // R10: back-pressure. First result (hit r1, allowed) waits while a second request waits too.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h2000_4100; req_priv = 1'b0; req_kind = 2'd0;
    ctl_enable = 1'b1; ctl_bg_priv = 1'b0; ctl_elev_enable = 1'b0; req_elevated = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h7000_1010; req_priv = 1'b1;   // second: r7, code 000 -> fault
    checks++;
    if (req_ready !== 1'b0) begin
      errors++;
      $display("FAIL R10 ready while stalled: got %b expected 0", req_ready);
    end
    repeat (2) @(negedge clk);
    check_rsp(10, 1'b0, 1'b1, 3'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(10, 1'b1, 1'b1, 3'd7);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 drain: got v=%b expected 0", rsp_valid);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule